// File: doc/BRIEF.md
# DMA Read Request Splitter with Tag Throttling

This block sits between a local DMA engine and a transaction-layer request port. The engine hands over one read command, a start address and a byte count. The splitter turns it into a run of memory read requests in ascending address order. No request is larger than the programmed maximum read request size, and no request crosses a 4 KB address boundary.

Every request carries a tag taken from a small pool. A request is only offered while a tag is free. The tag goes back to the pool when the completion logic reports that the last completion for it has arrived. The pool therefore limits how many reads can be in flight at once. With a pool of one, each read waits for the previous one to finish.

The 3-bit size field is taken from the configuration input at the moment the command is accepted. The command port stays busy until the last request has gone out. A done pulse is raised once every tag the command used has been returned.

Top module: `rdreq_splitter`

## Requirements
- R1: The 3-bit size field cfg_mrrs selects the largest request: value n in 0..5 gives 128·2^n bytes (0=128, 1=256, 2=512, 3=1024, 4=2048, 5=4096).
- R2: Field values 6 and 7 are reserved and behave as 128 bytes.
- R3: The requests of a command cover it exactly, in ascending address order. Each request starts where the previous one ended. Its length in bytes is the smallest of the bytes still to be fetched, the configured maximum, and the bytes left to the next 4 KB boundary.
- R4: No request crosses a 4 KB boundary: the low 12 address bits plus the length never exceed 4096.
- R5: cfg_mrrs is sampled only when a command is accepted. Changing it while the command is still running does not alter that command's split.
- R6: Each accepted request carries a tag that is not in flight, and at most NTAGS requests are in flight at once. While no tag is free, req_valid stays low.
- R7: A tag becomes reusable only after a cpl_done pulse carrying that tag. With all tags held, releasing one tag lets out exactly one more request, and that request uses the released tag.
- R8: cmd_ready is low from the cycle after a command is accepted until the command's done pulse.
- R9: cmd_done is a one-cycle pulse. It is raised only after the command's last request has been accepted and all its tags have been released. cmd_ready is high in that same cycle.
- R10: A zero-length command issues no request and still produces a done pulse.
- R11: While req_valid is high and req_ready is low, req_valid, req_addr and req_len hold their values.
- R12: After reset, cmd_ready is high, and req_valid and cmd_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mrrs | input | 3 | Encoded maximum read request size |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Splitter can take a command |
| cmd_addr | input | ADDR_W | Command start byte address |
| cmd_len | input | LEN_W | Command length in bytes |
| cmd_done | output | 1 | Pulse: command fully issued and all its tags returned |
| req_valid | output | 1 | Read request offered |
| req_ready | input | 1 | Request port accepts the request |
| req_addr | output | ADDR_W | Request byte address |
| req_len | output | 13 | Request length in bytes (1..4096) |
| req_tag | output | TAG_W | Tag assigned to the request |
| cpl_done | input | 1 | Pulse: last completion for a tag has arrived |
| cpl_tag | input | TAG_W | Tag being released |

## Verification
The bench targets the following corner cases:
- Commands that start just below a 4 KB boundary. A splitter that only honoured the size limit would emit a request straddling the page.
- The reserved size codes. A plain shift would yield 8 KB or 16 KB requests there.
- A size field scrambled every cycle during a command. This catches a design that reads the field live rather than latching it.
- Completions withheld altogether. This shows whether issue stalls at exactly the pool depth, and whether the single released tag is the one reused. A broken pool would either overrun or hand out a busy tag.
- Zero-length commands. They expose a done pulse that never arrives.
- A done pulse that comes too early, while tags are still in flight.

// File: rtl/rdsplit_pkg.sv
package rdsplit_pkg;

    localparam int REQ_LEN_W  = 13;
    localparam int PAGE_W     = 12;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } split_state_e;

    typedef struct packed {
        logic [REQ_LEN_W-1:0] len;
        logic                 last;
    } chunk_t;

    // Decode the 3-bit size code into bytes; reserved codes fall back to 128.
    function automatic logic [REQ_LEN_W-1:0] size_code_bytes(input logic [2:0] code);
        logic [REQ_LEN_W-1:0] b;
        if (code <= 3'd5) b = REQ_LEN_W'(128) << code;
        else              b = REQ_LEN_W'(128);
        return b;
    endfunction

endpackage

// File: rtl/rdsplit_chunk.sv
module rdsplit_chunk
    import rdsplit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 20
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [LEN_W-1:0]     remaining,
    input  logic [REQ_LEN_W-1:0] max_bytes,
    output chunk_t               chunk
);

    logic [REQ_LEN_W-1:0] to_page;
    logic [REQ_LEN_W-1:0] limit;
    logic [LEN_W-1:0]     limit_x;

    always_comb begin
        to_page = REQ_LEN_W'(PAGE_BYTES) - {1'b0, addr[PAGE_W-1:0]};
        limit   = (max_bytes < to_page) ? max_bytes : to_page;
        limit_x = LEN_W'(limit);
        if (remaining <= limit_x) begin
            chunk.len  = remaining[REQ_LEN_W-1:0];
            chunk.last = 1'b1;
        end else begin
            chunk.len  = limit;
            chunk.last = 1'b0;
        end
    end

endmodule

// File: rtl/rdsplit_tagpool.sv
module rdsplit_tagpool #(
    parameter int NTAGS = 8,
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic             rel,
    input  logic [TAG_W-1:0] rel_tag,
    output logic             any_free,
    output logic             all_free,
    output logic [TAG_W-1:0] free_tag
);

    logic [NTAGS-1:0] free_q;
    logic [NTAGS-1:0] free_d;

    always_comb begin
        free_tag = '0;
        for (int i = NTAGS - 1; i >= 0; i--) begin
            if (free_q[i]) free_tag = TAG_W'(i);
        end
        any_free = |free_q;
        all_free = &free_q;
    end

    always_comb begin
        free_d = free_q;
        if (alloc) free_d[free_tag] = 1'b0;
        if (rel && (int'(rel_tag) < NTAGS)) free_d[rel_tag] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) free_q <= '1;
        else     free_q <= free_d;
    end

    AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (rst)
        alloc |-> any_free && free_q[free_tag]);  // R6

    AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        alloc && !(rel && rel_tag == free_tag) |=> !free_q[$past(free_tag)]);  // R7

endmodule

// File: rtl/rdreq_splitter.sv
module rdreq_splitter
    import rdsplit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 20,
    parameter int NTAGS  = 8,
    localparam int TAG_W = (NTAGS > 1) ? $clog2(NTAGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           cfg_mrrs,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [LEN_W-1:0]     cmd_len,
    output logic                 cmd_done,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [ADDR_W-1:0]    req_addr,
    output logic [REQ_LEN_W-1:0] req_len,
    output logic [TAG_W-1:0]     req_tag,
    input  logic                 cpl_done,
    input  logic [TAG_W-1:0]     cpl_tag
);

    split_state_e         st_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [LEN_W-1:0]     rem_q;
    logic [REQ_LEN_W-1:0] maxb_q;
    logic                 done_q;

    chunk_t               chunk;
    logic                 any_free;
    logic                 all_free;
    logic [TAG_W-1:0]     free_tag;
    logic                 req_fire;
    logic                 cmd_fire;

    rdsplit_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chunk (
        .addr      (addr_q),
        .remaining (rem_q),
        .max_bytes (maxb_q),
        .chunk     (chunk)
    );

    rdsplit_tagpool #(.NTAGS(NTAGS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .alloc    (req_fire),
        .rel      (cpl_done),
        .rel_tag  (cpl_tag),
        .any_free (any_free),
        .all_free (all_free),
        .free_tag (free_tag)
    );

    assign cmd_ready = (st_q == ST_IDLE);
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign req_valid = (st_q == ST_ISSUE) && any_free;
    assign req_addr  = addr_q;
    assign req_len   = chunk.len;
    assign req_tag   = free_tag;
    assign req_fire  = req_valid && req_ready;
    assign cmd_done  = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            rem_q  <= '0;
            maxb_q <= size_code_bytes(3'd0);
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (cmd_fire) begin
                        addr_q <= cmd_addr;
                        rem_q  <= cmd_len;
                        maxb_q <= size_code_bytes(cfg_mrrs);
                        st_q   <= (cmd_len == '0) ? ST_DRAIN : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (req_fire) begin
                        addr_q <= addr_q + ADDR_W'(chunk.len);
                        rem_q  <= rem_q - LEN_W'(chunk.len);
                        if (chunk.last) st_q <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (all_free) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_WITHIN_MAX: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_len != '0) && (req_len <= maxb_q));  // R1

    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ({1'b0, req_addr[PAGE_W-1:0]} + req_len) <= REQ_LEN_W'(PAGE_BYTES));  // R4

    AST_SIZE_HELD: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE) |=> $stable(maxb_q));  // R5

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        cmd_fire |=> !cmd_ready);  // R8

    AST_DONE_TAGS_HOME: assert property (@(posedge clk) disable iff (rst)
        cmd_done |-> all_free && cmd_ready);  // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len));  // R11

endmodule

// File: tb/tb_rdreq_splitter.sv
module tb_rdreq_splitter;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 20;
    localparam int NTAGS  = 8;
    localparam int TAG_W  = 3;

    logic              clk;
    logic              rst;
    logic [2:0]        cfg_mrrs;
    logic              cmd_valid;
    logic              cmd_ready;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LEN_W-1:0]  cmd_len;
    logic              cmd_done;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic [12:0]       req_len;
    logic [TAG_W-1:0]  req_tag;
    logic              cpl_done;
    logic [TAG_W-1:0]  cpl_tag;

    rdreq_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NTAGS(NTAGS)) dut (
        .clk(clk), .rst(rst), .cfg_mrrs(cfg_mrrs),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_done(cmd_done),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_tag(req_tag),
        .cpl_done(cpl_done), .cpl_tag(cpl_tag)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int     n_vec, n_bad, cyc;
    bit     timeout;
    longint exp_a[$];
    longint exp_l[$];
    longint maxb_exp;
    bit     busy[NTAGS];
    int     tmr[NTAGS];
    bit     hold_cpl, scramble, cmd_pend, cmd_active, done_seen, prev_stall;
    int     force_rel, issued, last_tag;
    longint prev_a, prev_l;

    function automatic longint size_of(int code);
        return (code <= 5) ? (longint'(128) << code) : 128;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic build(longint a, longint l, int code);
        longint mb;
        mb = size_of(code);
        maxb_exp = mb;
        exp_a.delete();
        exp_l.delete();
        while (l > 0) begin
            longint lim, c;
            lim = 4096 - (a % 4096);
            if (mb < lim) lim = mb;
            c = (l < lim) ? l : lim;
            exp_a.push_back(a);
            exp_l.push_back(c);
            a += c;
            l -= c;
        end
    endtask

    task automatic step();
        int nb;
        @(negedge clk);
        cyc++;
        if (cyc > 190000 && !timeout) begin
            timeout = 1;
            n_bad++;
            $display("FAIL watchdog R9: actual %0d expected %0d", cyc, 190000);
        end
        cpl_done = 1'b0;
        if (force_rel >= 0) begin
            cpl_done = 1'b1;
            cpl_tag  = TAG_W'(force_rel);
            busy[force_rel] = 0;
            force_rel = -1;
        end else if (!hold_cpl) begin
            for (int t = 0; t < NTAGS; t++) begin
                if (busy[t] && tmr[t] == 0) begin
                    cpl_done = 1'b1;
                    cpl_tag  = TAG_W'(t);
                    busy[t]  = 0;
                    break;
                end
            end
        end
        for (int t = 0; t < NTAGS; t++) if (busy[t] && tmr[t] > 0) tmr[t]--;
        req_ready = ($urandom % 4) != 0;
        cmd_valid = cmd_pend;
        if (cmd_active && scramble) cfg_mrrs = 3'($urandom % 8);
        #1;
        nb = 0;
        for (int t = 0; t < NTAGS; t++) nb += busy[t];
        if (cmd_done) begin
            chk(cmd_active, "R9 done only for a running command", 0, 1);
            chk(exp_a.size() == 0, "R9 done after last request", exp_a.size(), 0);
            chk(nb == 0, "R9 done after all tags released", nb, 0);
            chk(cmd_ready, "R9 ready with done", cmd_ready, 1);
            done_seen  = 1;
            cmd_active = 0;
        end else if (cmd_active) begin
            if (cmd_ready) chk(0, "R8 ready low while command runs", 1, 0);
        end
        if (cmd_valid && cmd_ready) begin
            cmd_pend   = 0;
            cmd_active = 1;
        end
        if (req_valid && prev_stall) begin
            chk(req_addr == prev_a, "R11 addr held under stall", req_addr, prev_a);
            chk(req_len == prev_l, "R11 len held under stall", req_len, prev_l);
        end
        if (req_valid) chk(nb < NTAGS, "R6 no request with all tags busy", nb, NTAGS - 1);
        if (req_valid && req_ready) begin
            chk(!busy[req_tag], "R6 tag not in flight", req_tag, -1);
            if (exp_a.size() == 0) begin
                chk(0, "R3 unexpected extra request", req_addr, -1);
            end else begin
                chk(req_addr == exp_a[0], "R3 request address", req_addr, exp_a[0]);
                chk(req_len == exp_l[0], "R3 R5 request length", req_len, exp_l[0]);
                void'(exp_a.pop_front());
                void'(exp_l.pop_front());
            end
            chk(req_len <= maxb_exp, "R1 R2 length within max", req_len, maxb_exp);
            chk((req_addr % 4096) + req_len <= 4096, "R4 no page cross",
                (req_addr % 4096) + req_len, 4096);
            busy[req_tag] = 1;
            tmr[req_tag]  = $urandom % 8;
            issued++;
            last_tag = req_tag;
        end
        prev_stall = req_valid && !req_ready;
        prev_a = req_addr;
        prev_l = req_len;
    endtask

    task automatic start_cmd(longint a, longint l, int code);
        cfg_mrrs  = 3'(code);
        cmd_addr  = ADDR_W'(a);
        cmd_len   = LEN_W'(l);
        cmd_pend  = 1;
        done_seen = 0;
        issued    = 0;
        build(a, l, code);
    endtask

    task automatic run_cmd(longint a, longint l, int code);
        start_cmd(a, l, code);
        while (!done_seen && !timeout) step();
    endtask

    initial begin
        void'($urandom(32'd5150));
        n_vec = 0; n_bad = 0; cyc = 0; timeout = 0;
        hold_cpl = 0; scramble = 0; cmd_pend = 0; cmd_active = 0;
        force_rel = -1; prev_stall = 0; last_tag = -1;
        for (int t = 0; t < NTAGS; t++) begin busy[t] = 0; tmr[t] = 0; end
        rst = 1; cfg_mrrs = 0; cmd_valid = 0; cmd_addr = 0; cmd_len = 0;
        req_ready = 0; cpl_done = 0; cpl_tag = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(cmd_ready == 1, "R12 reset cmd_ready", cmd_ready, 1);
        chk(req_valid == 0, "R12 reset req_valid", req_valid, 0);
        chk(cmd_done == 0, "R12 reset cmd_done", cmd_done, 0);

        // R1: every legal size code on a page-aligned span
        for (int c = 0; c <= 5; c++) run_cmd(32'h0001_0000, 9000, c);
        // R2: reserved codes
        run_cmd(32'h0002_0000, 1000, 6);
        run_cmd(32'h0002_0000, 1000, 7);
        // R4: start just under a 4 KB boundary (expect 96 then 204)
        run_cmd(32'h0000_0FA0, 300, 5);
        run_cmd(32'h0000_1FFF, 5000, 4);
        // R10: zero length
        run_cmd(32'h0000_1234, 0, 3);
        chk(issued == 0, "R10 zero length issues nothing", issued, 0);
        // R5: size field scrambled mid-command
        scramble = 1;
        run_cmd(32'h0003_0040, 12000, 2);
        run_cmd(32'h0003_0800, 7000, 0);
        scramble = 0;

        // R6 / R7: withhold completions
        hold_cpl = 1;
        start_cmd(0, 65536, 0);
        repeat (60) step();
        chk(issued == NTAGS, "R6 issue stops at tag limit", issued, NTAGS);
        chk(req_valid == 0, "R6 req_valid low with no tag", req_valid, 0);
        force_rel = 3;
        repeat (25) step();
        chk(issued == NTAGS + 1, "R7 one release lets one request out", issued, NTAGS + 1);
        chk(last_tag == 3, "R7 released tag is reused", last_tag, 3);
        hold_cpl = 0;
        while (!done_seen && !timeout) step();

        // Random commands
        for (int k = 0; k < 120 && !timeout; k++) begin
            longint a, l;
            int sel;
            a = $urandom & 32'h7FFF_FFFF;
            sel = $urandom % 4;
            case (sel)
                0: l = 1 + $urandom % 300;
                1: l = $urandom % 5000;
                2: l = $urandom % 20000;
                default: l = 4096 * (1 + $urandom % 4);
            endcase
            scramble = ($urandom % 2) == 1;
            run_cmd(a, l, $urandom % 8);
        end
        scramble = 0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule